// File: doc/BRIEF.md
# Saturating Two-Mode PWM Generator

This block converts a signed 32-bit drive command into a single pulse-width-modulated line plus a pair of direction lines for a motor bridge. The command is first clamped into the signed range that the configured resolution `RES_W` can represent. The clamped value then becomes a duty reference in one of two ways, chosen by `mode_sel`.

In direction mode, the sign of the clamped value selects which direction line is active, and its magnitude sets the duty. This mode suits a bridge whose polarity is set by the direction pins. In bias mode, half of full scale is added to the clamped value, so a zero command gives half duty. This mode suits a bridge driven by a single offset duty cycle.

A free-running counter of `RES_W` bits sets the period. The duty reference and the direction lines are reloaded only when that counter wraps, so each period is produced from a single, consistent command.

Top module: `pwm_dir_bias_gen`

## Requirements
- R1: The command `cmd_in` is read as a two's-complement 32-bit integer and clamped to the range -2^(RES_W-1) .. 2^(RES_W-1)-1 before any further use. With `RES_W`=8 the range is -128..127.
- R2: In direction mode (`mode_sel`=0), a clamped value of zero or more gives `dir_fwd`=1 and `dir_rev`=0. A negative clamped value gives `dir_fwd`=0 and `dir_rev`=1.
- R3: In direction mode, `pwm_out` is high for 2*min(|clamped|, 2^(RES_W-1)-1) clocks of every period. A command of -2^(RES_W-1) therefore yields the same duty as +2^(RES_W-1)-1.
- R4: In bias mode (`mode_sel`=1), `pwm_out` is high for clamped + 2^(RES_W-1) clocks of every period. A zero command gives exactly half of the period.
- R5: The period is 2^RES_W clocks. Within a period, `pwm_out` is high in one contiguous run that starts at the first clock of the period and ends when the counter reaches the reference.
- R6: The command and mode are taken only on the clock that ends a period. A change in the middle of a period does not alter the rest of that period.
- R7: Reset is synchronous and active low. While reset is low, and afterwards until the first period boundary, `pwm_out`, `dir_fwd` and `dir_rev` are all low.
- R8: From the first period boundary after reset onwards, `dir_fwd` and `dir_rev` are complementary in both modes, and follow the sign of the clamped command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_in | input | 32 | Signed drive command |
| mode_sel | input | 1 | 0 = direction mode, 1 = bias mode |
| pwm_out | output | 1 | Pulse-width-modulated drive line |
| dir_fwd | output | 1 | Forward direction line |
| dir_rev | output | 1 | Reverse direction line |

## Verification
The properties assume that `rst_n` is low on the first clock edge, so that the reference, the counter and the direction registers start from known values. They make no assumption about how `cmd_in` or `mode_sel` change. The stimulus respects the reset assumption. It also changes the command at arbitrary points, including in the middle of a period and at values far outside the clamp range such as the most negative 32-bit integer. To make duty counts independent of where a period starts, each command is held for two full periods before its duty is counted.

// File: rtl/pwm_dir_bias_pkg.sv
// Package: shared types for the two-mode PWM generator.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_dir_bias_pkg;

    // Selects how the clamped command becomes a duty reference.
    typedef enum logic {
        MODE_DIR  = 1'b0,
        MODE_BIAS = 1'b1
    } drive_mode_e;

endpackage

// File: rtl/pwm_cmd_clamp.sv
// Module: clamps a signed 32-bit command into the signed RES_W-bit range.
// Assumes: 2 <= RES_W <= 31; purely combinational.
module pwm_cmd_clamp #(
    parameter int RES_W = 8
) (
    input  logic signed [31:0]      cmd_i,
    output logic        [RES_W-1:0] sat_o
);
    localparam logic signed [31:0] LIM_HI = (32'sd1 <<< (RES_W - 1)) - 32'sd1;
    localparam logic signed [31:0] LIM_LO = -(32'sd1 <<< (RES_W - 1));

    logic signed [31:0] held;

    // Pick the limit when the command leaves the representable range.
    always_comb begin
        if (cmd_i > LIM_HI)      held = LIM_HI;
        else if (cmd_i < LIM_LO) held = LIM_LO;
        else                     held = cmd_i;
    end

    assign sat_o = held[RES_W-1:0];
endmodule

// File: rtl/pwm_ref_map.sv
// Module: maps the clamped command to a duty reference and a sign flag.
// Assumes: sat_i is two's complement over RES_W bits; combinational.
module pwm_ref_map
    import pwm_dir_bias_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic [RES_W-1:0] sat_i,
    input  drive_mode_e      mode_i,
    output logic [RES_W-1:0] ref_o,
    output logic             neg_o
);
    localparam logic [RES_W-1:0] HALF    = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] MAG_MAX = {1'b0, {(RES_W-1){1'b1}}};

    logic [RES_W-1:0] mag;
    logic [RES_W-1:0] ref_dir;
    logic [RES_W-1:0] ref_bias;

    assign neg_o = sat_i[RES_W-1];

    // Magnitude of the clamped value, limited to the positive maximum.
    always_comb begin
        mag = neg_o ? (~sat_i + 1'b1) : sat_i;
        if (mag[RES_W-1]) mag = MAG_MAX;
    end

    // Direction mode doubles the magnitude to span the full period.
    assign ref_dir  = {mag[RES_W-2:0], 1'b0};
    // Bias mode shifts the signed value up by half scale.
    assign ref_bias = sat_i + HALF;

    // Choose the reference belonging to the selected mode.
    always_comb begin
        ref_o = (mode_i == MODE_BIAS) ? ref_bias : ref_dir;
    end
endmodule

// File: rtl/pwm_period_ctr.sv
// Module: free-running RES_W-bit period counter with a wrap flag.
// Assumes: synchronous active-low reset clears the count to zero.
module pwm_period_ctr #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RES_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [RES_W-1:0] cnt_q;

    // Advance once per clock, wrapping naturally at 2^RES_W.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = &cnt_q;
endmodule

// File: rtl/pwm_dir_bias_gen.sv
// Module: top of the two-mode saturating PWM generator.
// Assumes: rst_n low on the first clock edge; 2 <= RES_W <= 31.
// The reference and the direction lines reload only at the period wrap.
module pwm_dir_bias_gen
    import pwm_dir_bias_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cmd_in,
    input  logic        mode_sel,
    output logic        pwm_out,
    output logic        dir_fwd,
    output logic        dir_rev
);
    logic [RES_W-1:0] sat;
    logic [RES_W-1:0] ref_next;
    logic             neg_next;
    logic [RES_W-1:0] cnt_q;
    logic             wrap;
    logic [RES_W-1:0] ref_q;
    logic             armed;
    logic             fwd_q;
    logic             rev_q;
    drive_mode_e      mode;

    assign mode = drive_mode_e'(mode_sel);

    pwm_cmd_clamp #(.RES_W(RES_W)) u_clamp (
        .cmd_i (cmd_in),
        .sat_o (sat)
    );

    pwm_ref_map #(.RES_W(RES_W)) u_map (
        .sat_i  (sat),
        .mode_i (mode),
        .ref_o  (ref_next),
        .neg_o  (neg_next)
    );

    pwm_period_ctr #(.RES_W(RES_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt_q),
        .wrap_o (wrap)
    );

    // Take a new reference and direction only at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            fwd_q <= 1'b0;
            rev_q <= 1'b0;
            armed <= 1'b0;
        end else if (wrap) begin
            ref_q <= ref_next;
            fwd_q <= ~neg_next;
            rev_q <= neg_next;
            armed <= 1'b1;
        end
    end

    assign pwm_out = (cnt_q < ref_q);
    assign dir_fwd = fwd_q;
    assign dir_rev = rev_q;
endmodule

// File: rtl/pwm_dir_bias_chk.sv
// Module: property checker bound into pwm_dir_bias_gen.
// Assumes: rst_n is low on the first clock edge.
module pwm_dir_bias_chk #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [RES_W-1:0] cnt_q,
    input logic [RES_W-1:0] ref_q,
    input logic             armed,
    input logic             pwm_out,
    input logic             dir_fwd,
    input logic             dir_rev
);
    // R5: the counter steps by one on every clock.
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));

    // R5: a high run may start only at the first clock of a period.
    p_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (cnt_q == '0));

    // R5: a high run ends only where the counter meets the reference.
    p_fall_at_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> (cnt_q == ref_q));

    // R6: the reference cannot move inside a period.
    p_ref_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(ref_q));

    // R7: reset drives all three outputs low.
    p_reset_low_r7: assert property (@(posedge clk)
        !rst_n |=> (!pwm_out && !dir_fwd && !dir_rev));

    // R7: before the first boundary the outputs stay idle.
    p_idle_before_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!pwm_out && !dir_fwd && !dir_rev));

    // R8: once armed, the direction lines are complementary.
    p_dir_compl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (dir_fwd != dir_rev));
endmodule

bind pwm_dir_bias_gen pwm_dir_bias_chk #(.RES_W(RES_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_q   (cnt_q),
    .ref_q   (ref_q),
    .armed   (armed),
    .pwm_out (pwm_out),
    .dir_fwd (dir_fwd),
    .dir_rev (dir_rev)
);

// File: tb/sim_pwm_dir_bias_gen.sv
`timescale 1ns/1ps
// Bench: table-driven duty and direction checks, then directed reset and
// mid-period tests. RES_W = 8, so one period is 256 clocks.
module sim_pwm_dir_bias_gen;
    localparam int RES_W  = 8;
    localparam int PERIOD = 1 << RES_W;
    localparam int NVEC   = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cmd_in = '0;
    logic        mode_sel = 1'b0;
    logic        pwm_out;
    logic        dir_fwd;
    logic        dir_rev;

    int n_chk = 0;
    int n_bad = 0;

    // Table columns: mode, command, expected high clocks, forward, reverse.
    localparam logic        V_MODE [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
    localparam logic [31:0] V_CMD  [NVEC] = '{32'd0, 32'd10, -32'sd10, 32'd127,
        32'd1000, -32'sd128, -32'sd70000, 32'd0, 32'd100, -32'sd128, 32'd5000,
        -32'sd5, 32'h8000_0000};
    localparam int          V_HIGH [NVEC] = '{0, 20, 20, 254, 254, 254, 254,
        128, 228, 0, 255, 123, 0};
    localparam logic        V_FWD  [NVEC] = '{1, 1, 0, 1, 1, 0, 0, 1, 1, 0, 1, 0, 0};
    localparam logic        V_REV  [NVEC] = '{0, 0, 1, 0, 0, 1, 1, 0, 0, 1, 0, 1, 1};

    always #10 clk = ~clk;

    pwm_dir_bias_gen #(.RES_W(RES_W)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_in   (cmd_in),
        .mode_sel (mode_sel),
        .pwm_out  (pwm_out),
        .dir_fwd  (dir_fwd),
        .dir_rev  (dir_rev)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [PERIOD-1:0] smp;
        int highs;
        int rises;

        // R7: outputs low while reset is held.
        mode_sel = 1'b0;
        cmd_in   = 32'd50;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 pwm in reset", pwm_out, 0);
        check("R7 fwd in reset", dir_fwd, 0);
        check("R7 rev in reset", dir_rev, 0);
        rst_n = 1'b1;

        // R7: still idle before the first period boundary.
        repeat (200) @(posedge clk);
        @(negedge clk);
        check("R7 pwm before wrap", pwm_out, 0);
        check("R7 fwd before wrap", dir_fwd, 0);
        check("R7 rev before wrap", dir_rev, 0);

        // First boundary: reference 100 loaded, period starts high (R2, R5).
        repeat (56) @(posedge clk);
        @(negedge clk);
        check("R5 high at period start", pwm_out, 1);
        check("R2 fwd for positive", dir_fwd, 1);
        check("R8 rev complement", dir_rev, 0);

        // R6: a mid-period change must not disturb the running period.
        cmd_in = 32'd0;
        repeat (80) @(posedge clk);
        @(negedge clk);
        check("R6 old duty kept mid-period", pwm_out, 1);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R5 low after reference", pwm_out, 0);
        repeat (136) @(posedge clk);
        @(negedge clk);
        check("R6 new duty at next period", pwm_out, 0);

        // R7: reset in the middle of operation returns outputs low.
        cmd_in = 32'd100;
        repeat (2 * PERIOD) @(posedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 pwm after mid-run reset", pwm_out, 0);
        check("R7 fwd after mid-run reset", dir_fwd, 0);
        check("R7 rev after mid-run reset", dir_rev, 0);
        rst_n = 1'b1;

        // R1..R5, R8: table of commands, each held two periods, then counted.
        for (int v = 0; v < NVEC; v++) begin
            mode_sel = V_MODE[v];
            cmd_in   = V_CMD[v];
            repeat (2 * PERIOD) @(posedge clk);
            highs = 0;
            for (int i = 0; i < PERIOD; i++) begin
                @(negedge clk);
                smp[i] = pwm_out;
                if (pwm_out) highs++;
            end
            rises = 0;
            for (int i = 0; i < PERIOD; i++) begin
                if (smp[i] && !smp[(i + PERIOD - 1) % PERIOD]) rises++;
            end
            check(V_MODE[v] ? "R4 R1 bias duty" : "R3 R1 direction duty",
                  highs, V_HIGH[v]);
            check("R5 single high run", rises,
                  (V_HIGH[v] > 0 && V_HIGH[v] < PERIOD) ? 1 : 0);
            check("R2 R8 forward line", dir_fwd, V_FWD[v]);
            check("R2 R8 reverse line", dir_rev, V_REV[v]);
        end

        summary();
    end
endmodule